// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Engine

This block moves a block of bytes from one memory region to another using a pair of address/count channels. The source channel supplies the read address and the destination channel supplies the write address. Each channel holds a current address, a current word count, and a pair of base registers that are loaded together with the current registers. A one-cycle `start` pulse begins a service. Each transfer is a read cycle, which captures the returned byte into an 8-bit holding register, followed by a write cycle, which places that byte on `wdata` at the destination address.

The destination count decides when the service ends. The source count only wraps, and reloads the source channel when that option is on. The source address can be frozen so that one source byte fills a whole destination block. An external end-of-process input stops the service once the current read/write pair has finished. That external stop reloads only the destination channel and never the source. The address-enable output is high for the whole service. The block has no device acknowledge outputs and no compressed timing, so every transfer takes exactly two clock cycles.

Top module: `m2m_dma_pair`

## Requirements
- R1: After reset `aen`, `mem_rd`, `mem_wr`, `eop_out` and `tc_flag` are all 0.
- R2: Every transfer is one cycle with `mem_rd`=1 followed directly by one cycle with `mem_wr`=1. `wdata` in the write cycle equals the `rdata` returned during the read cycle. The two strobes are never both high.
- R3: Each channel's address moves by one per transfer, downward when its decrement input is 1 and upward when it is 0, with 16-bit wraparound.
- R4: With `src_hold`=1 every read uses the same source address.
- R5: A source count that wraps from 0 to all ones does not end the service, does not set `tc_flag` and does not assert `eop_out`. When `src_auto`=1 that transfer also reloads the source base address and base count, so the next read starts again at the source base.
- R6: A service started with destination count C performs C+1 transfers unless stopped externally. `eop_out` is 1 only during the final write cycle. `tc_flag` becomes 1 in the cycle after that write and stays 1 until the next `start`.
- R7: With `dst_auto`=1, the destination address and count reload from their base values when a service ends, so the next `start` writes the same destination block again.
- R8: If `eop_in` is 1 during a read or write cycle of a service, the service ends after that transfer's write. `aen` is 0 in the following cycle, `tc_flag` stays 0 and `eop_out` is not asserted.
- R9: An external stop never reloads the source channel. A later service continues from the next source address. The same stop reloads the destination channel when `dst_auto`=1.
- R10: `aen` is 1 in every read and write cycle of a service and 0 while idle. `cfg_we` is acted on only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load base and current registers of both channels (idle only) |
| cfg_src_addr | input | 16 | Source start address |
| cfg_src_cnt | input | 16 | Source word count (transfers minus one) |
| cfg_dst_addr | input | 16 | Destination start address |
| cfg_dst_cnt | input | 16 | Destination word count (transfers minus one) |
| src_dec | input | 1 | Source address steps downward |
| dst_dec | input | 1 | Destination address steps downward |
| src_hold | input | 1 | Keep source address fixed |
| src_auto | input | 1 | Reload source channel on source count wrap |
| dst_auto | input | 1 | Reload destination channel at end of service |
| start | input | 1 | Begin a service (idle only) |
| eop_in | input | 1 | External end-of-process request |
| rdata | input | 8 | Read data returned by memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| aen | output | 1 | Address enable, high during service |
| addr | output | 16 | Memory address for current cycle |
| wdata | output | 8 | Write data (captured byte) |
| eop_out | output | 1 | End-of-process on destination terminal count |
| tc_flag | output | 1 | Terminal-count status |

## Verification
The bench sweeps source and destination counts against every combination of hold, direction and source reload. A source block shorter than the destination block shows whether source wrap reloads or runs on. Equal counts show that only the destination count ends the service. A repeated start shows the destination reload. A second group of tests raises `eop_in` mid-block with the source reload enabled and a long source count. This separates an external stop, which must leave the source position intact and skip `tc_flag`, from a count-driven end.

// File: rtl/m2m_pkg.sv
package m2m_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } m2m_state_e;
endpackage

// File: rtl/m2m_chan.sv
module m2m_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          step,
  input  logic          hold,
  input  logic          dec,
  input  logic          auto_en,
  input  logic          ext_reload,
  output logic [AW-1:0] cur_addr,
  output logic          cnt_zero
);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [AW-1:0] base_addr_q, addr_q, addr_d;
  logic [CW-1:0] base_cnt_q, cnt_q, cnt_d;
  logic          cur_en, reload;

  assign cnt_zero = (cnt_q == '0);
  assign reload   = auto_en && (cnt_zero || ext_reload);
  assign cur_en   = cfg_we || step;
  assign cur_addr = addr_q;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (cfg_we) begin
      addr_d = cfg_addr;
      cnt_d  = cfg_cnt;
    end else if (step) begin
      if (reload) begin
        addr_d = base_addr_q;
        cnt_d  = base_cnt_q;
      end else begin
        if (!hold) addr_d = dec ? (addr_q - ONE_A) : (addr_q + ONE_A);
        cnt_d = cnt_q - ONE_C;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else if (cfg_we) begin
      base_addr_q <= cfg_addr;
      base_cnt_q  <= cfg_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (cur_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/m2m_seq.sv
module m2m_seq #(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                eop_in,
  input  logic                dst_zero,
  input  logic [DW-1:0]       rdata,
  output m2m_pkg::m2m_state_e state,
  output logic                step,
  output logic                ext_term,
  output logic                tc_flag,
  output logic [DW-1:0]       hold_byte
);
  import m2m_pkg::*;

  m2m_state_e    st_q, st_d;
  logic          eop_seen_q, eop_seen_d;
  logic          tc_q, tc_d;
  logic [DW-1:0] byte_q;
  logic          byte_en;

  assign state     = st_q;
  assign step      = (st_q == ST_WR);
  assign ext_term  = step && (eop_seen_q || eop_in);
  assign tc_flag   = tc_q;
  assign hold_byte = byte_q;
  assign byte_en   = (st_q == ST_RD);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = (dst_zero || ext_term) ? ST_IDLE : ST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    eop_seen_d = eop_seen_q;
    if (st_q == ST_WR)      eop_seen_d = 1'b0;
    else if (st_q == ST_RD) eop_seen_d = eop_seen_q || eop_in;
  end

  always_comb begin
    tc_d = tc_q;
    if (st_q == ST_IDLE && start)    tc_d = 1'b0;
    else if (st_q == ST_WR && dst_zero) tc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      eop_seen_q <= 1'b0;
      tc_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      eop_seen_q <= eop_seen_d;
      tc_q       <= tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= rdata;
  end
endmodule

// File: rtl/m2m_dma_pair.sv
module m2m_dma_pair #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [CW-1:0] cfg_src_cnt,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_dst_cnt,
  input  logic          src_dec,
  input  logic          dst_dec,
  input  logic          src_hold,
  input  logic          src_auto,
  input  logic          dst_auto,
  input  logic          start,
  input  logic          eop_in,
  input  logic [DW-1:0] rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          aen,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          eop_out,
  output logic          tc_flag
);
  import m2m_pkg::*;

  m2m_state_e    state;
  logic          step, ext_term, dst_zero, src_zero_unused;
  logic          cfg_ok;
  logic [AW-1:0] src_addr, dst_addr;

  assign cfg_ok = cfg_we && (state == ST_IDLE);

  m2m_chan #(.AW(AW), .CW(CW)) u_src (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_ok),
    .cfg_addr(cfg_src_addr), .cfg_cnt(cfg_src_cnt),
    .step(step), .hold(src_hold), .dec(src_dec), .auto_en(src_auto),
    .ext_reload(1'b0), .cur_addr(src_addr), .cnt_zero(src_zero_unused)
  );

  m2m_chan #(.AW(AW), .CW(CW)) u_dst (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_ok),
    .cfg_addr(cfg_dst_addr), .cfg_cnt(cfg_dst_cnt),
    .step(step), .hold(1'b0), .dec(dst_dec), .auto_en(dst_auto),
    .ext_reload(ext_term), .cur_addr(dst_addr), .cnt_zero(dst_zero)
  );

  m2m_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .eop_in(eop_in),
    .dst_zero(dst_zero), .rdata(rdata), .state(state), .step(step),
    .ext_term(ext_term), .tc_flag(tc_flag), .hold_byte(wdata)
  );

  assign mem_rd  = (state == ST_RD);
  assign mem_wr  = (state == ST_WR);
  assign aen     = (state != ST_IDLE);
  assign addr    = mem_rd ? src_addr : dst_addr;
  assign eop_out = mem_wr && dst_zero;

  logic unused_ok;
  assign unused_ok = src_zero_unused;
endmodule

// File: rtl/m2m_dma_pair_chk.sv
module m2m_dma_pair_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          eop_in,
  input logic          src_hold,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          aen,
  input logic [AW-1:0] addr,
  input logic          eop_out,
  input logic          tc_flag
);
  logic [AW-1:0] last_rd_q;
  logic          last_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd_q <= '0;
      last_ok_q <= 1'b0;
    end else if (!aen || !src_hold) begin
      last_ok_q <= 1'b0;
    end else if (mem_rd) begin
      last_rd_q <= addr;
      last_ok_q <= 1'b1;
    end
  end

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R2
  AST_AEN_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> aen); // R10
  AST_EOP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |-> mem_wr); // R6
  AST_TC_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |=> (tc_flag && !aen)); // R6
  AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !aen) |=> !tc_flag); // R6
  AST_HOLD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && src_hold && last_ok_q) |-> (addr == last_rd_q)); // R4
  AST_EXT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && eop_in) |=> mem_wr ##1 !aen); // R8
endmodule

bind m2m_dma_pair m2m_dma_pair_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .eop_in(eop_in),
  .src_hold(src_hold), .mem_rd(mem_rd), .mem_wr(mem_wr), .aen(aen),
  .addr(addr), .eop_out(eop_out), .tc_flag(tc_flag)
);

// File: tb/m2m_dma_pair_tb.sv
`timescale 1ns/1ps
module m2m_dma_pair_tb;
  logic        clk, rst_n;
  logic        cfg_we, src_dec, dst_dec, src_hold, src_auto, dst_auto, start, eop_in;
  logic [15:0] cfg_src_addr, cfg_src_cnt, cfg_dst_addr, cfg_dst_cnt, addr;
  logic [7:0]  rdata, wdata;
  logic        mem_rd, mem_wr, aen, eop_out, tc_flag;

  int total = 0, bad = 0;
  int gidx = 0;
  bit done = 0;

  m2m_dma_pair u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rdata = memf(addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] src_exp(input int g);
    int off;
    off = src_hold ? 0 : (src_auto ? g % (int'(cfg_src_cnt) + 1) : g);
    return src_dec ? cfg_src_addr - 16'(off) : cfg_src_addr + 16'(off);
  endfunction

  function automatic logic [15:0] dst_exp(input int k);
    return dst_dec ? cfg_dst_addr - 16'(k) : cfg_dst_addr + 16'(k);
  endfunction

  task automatic configure(input logic [15:0] sa, sc, da, dc);
    @(negedge clk);
    cfg_src_addr = sa; cfg_src_cnt = sc; cfg_dst_addr = da; cfg_dst_cnt = dc;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    gidx = 0;
  endtask

  // eop_at < 0: count-driven end; otherwise raise eop_in at that transfer's read
  task automatic run(input int n_exp, input int eop_at);
    int k = 0, guard = 0;
    bit phase_rd = 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (aen && guard < 1000) begin
      eop_in = 1'b0;
      guard++;
      chk(mem_rd == phase_rd && mem_wr == !phase_rd, "R2/R10 strobe order", {mem_rd, mem_wr}, {phase_rd, !phase_rd});
      if (mem_rd) begin
        chk(addr == src_exp(gidx), "R3/R4/R5/R9 src addr", addr, src_exp(gidx));
        if (k == eop_at) eop_in = 1'b1;
      end else if (mem_wr) begin
        chk(addr == dst_exp(k), "R3/R7 dst addr", addr, dst_exp(k));
        chk(wdata == memf(src_exp(gidx)), "R2 data", wdata, memf(src_exp(gidx)));
        chk(eop_out == (eop_at < 0 && k == n_exp - 1), "R5/R6/R8 eop_out", eop_out, (eop_at < 0 && k == n_exp - 1));
        k++; gidx++;
      end
      phase_rd = !phase_rd;
      @(negedge clk);
    end
    eop_in = 1'b0;
    chk(k == n_exp, "R6/R8 transfer count", k, n_exp);
    chk(!aen && !mem_rd && !mem_wr, "R10 idle after service", aen, 0);
    chk(tc_flag == (eop_at < 0), "R6/R8 tc_flag", tc_flag, (eop_at < 0));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; start = 0; eop_in = 0;
    src_dec = 0; dst_dec = 0; src_hold = 0; src_auto = 0; dst_auto = 0;
    cfg_src_addr = 0; cfg_src_cnt = 0; cfg_dst_addr = 0; cfg_dst_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!aen && !mem_rd && !mem_wr && !eop_out && !tc_flag, "R1 reset", {aen, mem_rd, mem_wr, eop_out, tc_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: hold, directions, source reload, destination reload, counts
    for (int h = 0; h < 2; h++)
      for (int sd = 0; sd < 2; sd++)
        for (int dd = 0; dd < 2; dd++)
          for (int sa = 0; sa < 2; sa++)
            for (int da = 0; da < 2; da++)
              for (int sc = 0; sc < 3; sc++)
                for (int dc = 0; dc < 5; dc += 2) begin
                  src_hold = h[0]; src_dec = sd[0]; dst_dec = dd[0];
                  src_auto = sa[0]; dst_auto = da[0];
                  configure(16'h0001 + 16'(sc * 16'h0100), 16'(sc), 16'hFFFE, 16'(dc));
                  run(dc + 1, -1);
                  if (da) run(dc + 1, -1); // R7: destination reloaded
                end

    // R8/R9: external stop, source keeps position, destination reloads
    src_hold = 0; src_dec = 0; dst_dec = 0; src_auto = 1; dst_auto = 1;
    configure(16'h4000, 16'd11, 16'h8000, 16'd9);
    run(4, 3);
    run(2, 1);
    run(10, -1);
    // R8: stop requested on the very first transfer
    src_dec = 1; dst_dec = 1;
    configure(16'h1234, 16'd20, 16'h0002, 16'd5);
    run(1, 0);
    run(6, -1);

    // R10: configuration ignored while busy
    src_dec = 0; dst_dec = 0; src_auto = 0; dst_auto = 0;
    configure(16'h2000, 16'd50, 16'h3000, 16'd3);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_src_addr = 16'h7777; cfg_dst_addr = 16'h6666; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(mem_wr && addr == 16'h3000, "R10 cfg ignored busy", addr, 16'h3000);
    @(negedge clk);
    chk(mem_rd && addr == 16'h2001, "R10 cfg ignored busy src", addr, 16'h2001);
    repeat (8) @(negedge clk);
    chk(!aen && tc_flag, "R6 end after busy cfg", {aen, tc_flag}, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule